// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor core that completes one instruction in every clock cycle. Each cycle it fetches a word from an internal instruction store, decodes it, reads two operands from a 32-entry register file, and runs them through an ALU. It then writes back to the register file or the data store, and picks the next program counter. Both stores are word-addressed internal arrays. The instruction store is filled through a load port while the core is held in reset.

The instruction set covers R-format arithmetic and logic, load word, store word, branch-if-equal, jump-register and load-upper-immediate. Jump-register reuses the R-format opcode. Its funct code suppresses the register write and routes the first register operand to the program counter. Load-upper-immediate adds a third source to the write-back selector. Debug outputs show the program counter and the register write port, so that a test environment can follow execution instruction by instruction.

Instruction fields: opcode is bits 31–26, rs is bits 25–21, rt is bits 20–16, rd is bits 15–11, imm is bits 15–0 and funct is bits 5–0. "sext" means the 16-bit imm sign-extended to 32 bits.

Top module: `sc_cpu`

## Requirements
- R1: While `rst` is high at a rising edge, the core does the following: the PC becomes 0, all 32 registers and all data words become 0, and no register or data write takes place. `dbg_wen` stays low while `rst` is high.
- R2: Unless an instruction below redirects it, the PC increases by 4 on every rising edge.
- R3: Opcode 0x00 writes rd with the result of an operation on rs and rt, chosen by funct: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed set-less-than (1 or 0). Any other funct except 0x08 performs add.
- R4: Register 0 always reads as zero. A write aimed at it still appears on the debug port but is discarded.
- R5: Load word (opcode 0x23) writes rt with the data word at byte address rs+sext. The word index is address bits [log2(DMEM_WORDS)+1:2], so addresses wrap modulo the store depth.
- R6: Store word (opcode 0x2B) writes rt into the data word at byte address rs+sext, indexed as in R5, and writes no register.
- R7: Branch-if-equal (opcode 0x04) sets the PC to PC+4+(sext<<2) when rs equals rt, and to PC+4 otherwise. It writes nothing.
- R8: Jump-register (opcode 0x00, funct 0x08) loads the PC with the value of rs and writes neither a register nor memory.
- R9: Load-upper-immediate (opcode 0x0F) writes rt with imm in bits 31–16 and zeros in bits 15–0.
- R10: When `ld_en` is high at a rising edge, the instruction word at index `ld_addr` is replaced by `ld_data`. Fetch uses PC bits [log2(IMEM_WORDS)+1:2] as the index.
- R11: Any other opcode writes nothing and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Instruction store write strobe |
| ld_addr | input | log2(IMEM_WORDS) | Instruction word index to write |
| ld_data | input | 32 | Instruction word to write |
| dbg_pc | output | 32 | Current program counter |
| dbg_wen | output | 1 | Register write enable this cycle |
| dbg_waddr | output | 5 | Register write index this cycle |
| dbg_wdata | output | 32 | Register write value this cycle |

## Verification
The bench instantiates the core with IMEM_WORDS=128 and DMEM_WORDS=16. The larger instruction store holds a directed prefix, a jump-register target at byte address 128, and a randomized body. The 16-word data store lets random load and store offsets range over twice its depth, so aliased addresses that wrap onto the same word (R5, R6) are reached often. Every cycle, the write port and PC are compared against an instruction-level model kept in the bench.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam logic [5:0] OPC_RTYPE = 6'h00;
    localparam logic [5:0] OPC_BEQ   = 6'h04;
    localparam logic [5:0] OPC_LUI   = 6'h0F;
    localparam logic [5:0] OPC_LW    = 6'h23;
    localparam logic [5:0] OPC_SW    = 6'h2B;

    localparam logic [5:0] FN_JR  = 6'h08;
    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [1:0] {
        WB_ALU   = 2'd0,
        WB_MEM   = 2'd1,
        WB_UPPER = 2'd2
    } wb_sel_e;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_AND = 3'd2,
        ALU_OR  = 3'd3,
        ALU_SLT = 3'd4
    } alu_fn_e;

    typedef struct packed {
        logic       reg_dst;
        logic       alu_src;
        wb_sel_e    wb_sel;
        logic       reg_write;
        logic       mem_read;
        logic       mem_write;
        logic       branch;
        logic       jump_reg;
        logic [1:0] alu_op;
    } ctrl_t;

endpackage

// File: rtl/sc_main_ctrl.sv
module sc_main_ctrl
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);

    always_comb begin
        ctrl        = '0;
        ctrl.wb_sel = WB_ALU;
        unique case (opcode)
            OPC_RTYPE: begin
                ctrl.reg_dst = 1'b1;
                ctrl.alu_op  = 2'b10;
                if (funct == FN_JR) begin
                    ctrl.jump_reg = 1'b1;
                end else begin
                    ctrl.reg_write = 1'b1;
                end
            end
            OPC_LW: begin
                ctrl.alu_src   = 1'b1;
                ctrl.wb_sel    = WB_MEM;
                ctrl.reg_write = 1'b1;
                ctrl.mem_read  = 1'b1;
            end
            OPC_SW: begin
                ctrl.alu_src   = 1'b1;
                ctrl.mem_write = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.branch = 1'b1;
                ctrl.alu_op = 2'b01;
            end
            OPC_LUI: begin
                ctrl.wb_sel    = WB_UPPER;
                ctrl.reg_write = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/sc_alu_ctrl.sv
module sc_alu_ctrl
    import sc_pkg::*;
(
    input  logic [1:0] alu_op,
    input  logic [5:0] funct,
    output alu_fn_e    fn
);

    always_comb begin
        unique case (alu_op)
            2'b00:   fn = ALU_ADD;
            2'b01:   fn = ALU_SUB;
            default: begin
                case (funct)
                    FN_SUB:  fn = ALU_SUB;
                    FN_AND:  fn = ALU_AND;
                    FN_OR:   fn = ALU_OR;
                    FN_SLT:  fn = ALU_SLT;
                    default: fn = ALU_ADD;
                endcase
            end
        endcase
    end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_fn_e      fn,
    output logic [W-1:0] y,
    output logic         zero
);

    logic lt;
    assign lt = $signed(a) < $signed(b);

    always_comb begin
        unique case (fn)
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(W-1){1'b0}}, lt};
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int W    = 32,
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2
);

    logic [W-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) begin
                regs[i] <= '0;
            end
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    assign rd1 = regs[ra1];
    assign rd2 = regs[ra2];

    AST_ZERO_REG_READ: assert property (@(posedge clk) disable iff (rst)
        (ra1 == '0) |-> (rd1 == '0)); // R4

endmodule

// File: rtl/sc_cpu.sv
module sc_cpu
    import sc_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    localparam int IAW = $clog2(IMEM_WORDS),
    localparam int DAW = $clog2(DMEM_WORDS)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           ld_en,
    input  logic [IAW-1:0] ld_addr,
    input  logic [31:0]    ld_data,
    output logic [31:0]    dbg_pc,
    output logic           dbg_wen,
    output logic [4:0]     dbg_waddr,
    output logic [31:0]    dbg_wdata
);

    logic [31:0] pc_q, pc_next, pc_inc, br_off;
    logic [31:0] instr;
    logic [31:0] imem [IMEM_WORDS];
    logic [31:0] dmem [DMEM_WORDS];

    logic [5:0]  opcode, funct;
    logic [4:0]  rs, rt, rd, wa;
    logic [15:0] imm;
    logic [31:0] sext, rs_val, rt_val, alu_b, alu_y, mem_rdata, wb_data;
    logic        alu_zero, take_br, rf_we, mem_we;
    logic [DAW-1:0] didx;
    ctrl_t       ctrl;
    alu_fn_e     fn;

    // instruction store: written only through the load port
    always_ff @(posedge clk) begin
        if (ld_en) begin
            imem[ld_addr] <= ld_data;
        end
    end

    assign instr  = imem[pc_q[IAW+1:2]];
    assign opcode = instr[31:26];
    assign rs     = instr[25:21];
    assign rt     = instr[20:16];
    assign rd     = instr[15:11];
    assign imm    = instr[15:0];
    assign funct  = instr[5:0];
    assign sext   = {{16{imm[15]}}, imm};

    sc_main_ctrl u_ctrl (
        .opcode (opcode),
        .funct  (funct),
        .ctrl   (ctrl)
    );

    sc_alu_ctrl u_aluctl (
        .alu_op (ctrl.alu_op),
        .funct  (funct),
        .fn     (fn)
    );

    assign wa    = ctrl.reg_dst ? rd : rt;
    assign rf_we = ctrl.reg_write & ~rst;

    sc_regfile #(.W(32), .NREG(32)) u_rf (
        .clk (clk),
        .rst (rst),
        .we  (rf_we),
        .wa  (wa),
        .wd  (wb_data),
        .ra1 (rs),
        .ra2 (rt),
        .rd1 (rs_val),
        .rd2 (rt_val)
    );

    assign alu_b = ctrl.alu_src ? sext : rt_val;

    sc_alu #(.W(32)) u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .fn   (fn),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // data store: word indexed, wraps modulo its depth
    assign didx   = alu_y[DAW+1:2];
    assign mem_we = ctrl.mem_write & ~rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DMEM_WORDS; i++) begin
                dmem[i] <= '0;
            end
        end else if (mem_we) begin
            dmem[didx] <= rt_val;
        end
    end

    assign mem_rdata = ctrl.mem_read ? dmem[didx] : '0;

    always_comb begin
        unique case (ctrl.wb_sel)
            WB_MEM:   wb_data = mem_rdata;
            WB_UPPER: wb_data = {imm, 16'h0000};
            default:  wb_data = alu_y;
        endcase
    end

    // next program counter
    assign pc_inc  = pc_q + 32'd4;
    assign br_off  = {sext[29:0], 2'b00};
    assign take_br = ctrl.branch & alu_zero;

    always_comb begin
        if (ctrl.jump_reg) begin
            pc_next = rs_val;
        end else if (take_br) begin
            pc_next = pc_inc + br_off;
        end else begin
            pc_next = pc_inc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_next;
        end
    end

    assign dbg_pc    = pc_q;
    assign dbg_wen   = rf_we;
    assign dbg_waddr = wa;
    assign dbg_wdata = wb_data;

    logic unused_bits;
    assign unused_bits = ^{pc_q[1:0], pc_q[31:IAW+2], alu_y[1:0], alu_y[31:DAW+2],
                           instr[10:6], sext[31:30]};

    AST_RESET_PC: assert property (@(posedge clk)
        rst |=> (pc_q == '0)); // R1
    AST_STEP_PC: assert property (@(posedge clk) disable iff (rst)
        (!take_br && !ctrl.jump_reg) |=> (pc_q == $past(pc_q) + 32'd4)); // R2
    AST_BRANCH_TGT: assert property (@(posedge clk) disable iff (rst)
        take_br |=> (pc_q == $past(pc_q) + 32'd4 + $past(br_off))); // R7
    AST_JR_TGT: assert property (@(posedge clk) disable iff (rst)
        ctrl.jump_reg |=> (pc_q == $past(rs_val))); // R8
    AST_JR_QUIET: assert property (@(posedge clk) disable iff (rst)
        ctrl.jump_reg |-> (!dbg_wen && !mem_we)); // R8
    AST_STORE_NO_REG: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !dbg_wen); // R6
    AST_UPPER_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
        (ctrl.wb_sel == WB_UPPER) |-> (dbg_wdata[15:0] == 16'h0000)); // R9

endmodule

// File: tb/sc_cpu_test.sv
`timescale 1ns/1ps
module sc_cpu_test;

    localparam int IM  = 128;
    localparam int DM  = 16;
    localparam int IAW = $clog2(IM);
    localparam int RUN_CYCLES = 260;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           ld_en = 1'b0;
    logic [IAW-1:0] ld_addr = '0;
    logic [31:0]    ld_data = '0;
    logic [31:0]    dbg_pc;
    logic           dbg_wen;
    logic [4:0]     dbg_waddr;
    logic [31:0]    dbg_wdata;

    sc_cpu #(.IMEM_WORDS(IM), .DMEM_WORDS(DM)) uut (
        .clk       (clk),
        .rst       (rst),
        .ld_en     (ld_en),
        .ld_addr   (ld_addr),
        .ld_data   (ld_data),
        .dbg_pc    (dbg_pc),
        .dbg_wen   (dbg_wen),
        .dbg_waddr (dbg_waddr),
        .dbg_wdata (dbg_wdata)
    );

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [31:0] prog [IM];
    logic [31:0] mreg [32];
    logic [31:0] mmem [DM];
    logic [31:0] mpc;

    logic        e_wen, e_mwe;
    logic [4:0]  e_wa;
    logic [31:0] e_wd, e_npc, e_maddr, e_mdata;

    function automatic logic [31:0] enc_r(input logic [4:0] rs, rt, rd, input logic [5:0] fn);
        return {6'h00, rs, rt, rd, 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs, rt,
                                          input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic logic [31:0] halt_word();
        return enc_i(6'h04, 5'd0, 5'd0, 16'hFFFF);
    endfunction

    function automatic string req_of(input logic [31:0] ins);
        case (ins[31:26])
            6'h00: begin
                if (ins[5:0] == 6'h08) return "R8";
                if (ins[25:21] == 0 || ins[20:16] == 0 || ins[15:11] == 0) return "R4";
                return "R3";
            end
            6'h23:   return "R5";
            6'h2B:   return "R6";
            6'h04:   return "R7";
            6'h0F:   return "R9";
            default: return "R11";
        endcase
    endfunction

    function automatic logic [31:0] ref_alu(input logic [5:0] fn, input logic [31:0] a, b);
        case (fn)
            6'h22:   return a - b;
            6'h24:   return a & b;
            6'h25:   return a | b;
            6'h2A:   return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            default: return a + b;
        endcase
    endfunction

    task automatic model_eval(output logic [31:0] ins);
        logic [31:0] sx, va, vb;
        ins     = prog[(mpc >> 2) % IM];
        sx      = {{16{ins[15]}}, ins[15:0]};
        va      = mreg[ins[25:21]];
        vb      = mreg[ins[20:16]];
        e_wen   = 1'b0;
        e_mwe   = 1'b0;
        e_wa    = '0;
        e_wd    = '0;
        e_maddr = '0;
        e_mdata = '0;
        e_npc   = mpc + 32'd4;
        case (ins[31:26])
            6'h00: begin
                if (ins[5:0] == 6'h08) begin
                    e_npc = va;
                end else begin
                    e_wen = 1'b1;
                    e_wa  = ins[15:11];
                    e_wd  = ref_alu(ins[5:0], va, vb);
                end
            end
            6'h23: begin
                e_wen = 1'b1;
                e_wa  = ins[20:16];
                e_wd  = mmem[((va + sx) >> 2) % DM];
            end
            6'h2B: begin
                e_mwe   = 1'b1;
                e_maddr = ((va + sx) >> 2) % DM;
                e_mdata = vb;
            end
            6'h04: begin
                if (va == vb) e_npc = mpc + 32'd4 + {sx[29:0], 2'b00};
            end
            6'h0F: begin
                e_wen = 1'b1;
                e_wa  = ins[20:16];
                e_wd  = {ins[15:0], 16'h0000};
            end
            default: begin
            end
        endcase
    endtask

    task automatic model_commit();
        if (e_mwe) mmem[e_maddr] = e_mdata;
        if (e_wen && e_wa != 0) mreg[e_wa] = e_wd;
        mpc = e_npc;
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] act, exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic build_prog();
        int k;
        logic [4:0] a, b, d;
        logic [5:0] fns [5];
        fns[0] = 6'h20; fns[1] = 6'h22; fns[2] = 6'h24; fns[3] = 6'h25; fns[4] = 6'h2A;
        for (int i = 0; i < IM; i++) prog[i] = halt_word();
        // directed prefix
        prog[0]  = enc_i(6'h0F, 5'd0, 5'd2, 16'h0001);         // lui r2 -> 0x10000
        prog[1]  = enc_r(5'd0, 5'd2, 5'd3, 6'h2A);             // slt r3 = 1
        for (int i = 2; i <= 8; i++) prog[i] = enc_r(5'd3, 5'd3, 5'd3, 6'h20); // r3 -> 128
        prog[9]  = enc_i(6'h2B, 5'd0, 5'd2, 16'h0004);         // sw r2, 4(r0)
        prog[10] = enc_i(6'h23, 5'd0, 5'd4, 16'h0044);         // lw r4, 0x44 (wraps to word 1)
        prog[11] = enc_i(6'h04, 5'd4, 5'd2, 16'h0002);         // beq taken -> 14
        prog[12] = enc_r(5'd3, 5'd3, 5'd5, 6'h20);
        prog[13] = enc_r(5'd3, 5'd3, 5'd5, 6'h20);
        prog[14] = enc_i(6'h04, 5'd3, 5'd2, 16'h0005);         // beq not taken
        prog[15] = enc_r(5'd3, 5'd3, 5'd0, 6'h20);             // write to r0
        prog[16] = enc_r(5'd0, 5'd0, 5'd6, 6'h25);             // r6 = r0|r0
        prog[17] = enc_i(6'h3F, 5'd3, 5'd7, 16'h1234);         // unknown opcode
        prog[18] = enc_r(5'd0, 5'd3, 5'd8, 6'h3F);             // unknown funct -> add
        prog[19] = enc_r(5'd3, 5'd0, 5'd0, 6'h08);             // jr r3 -> 128
        // random body
        for (int i = 32; i < 112; i++) begin
            k = $urandom % 10;
            a = 5'($urandom % 8);
            b = 5'(1 + $urandom % 7);
            d = 5'(1 + $urandom % 7);
            case (k)
                0, 1, 2, 3, 4: prog[i] = enc_r(a, b, d, fns[$urandom % 5]);
                5: prog[i] = enc_i(6'h0F, 5'd0, d, 16'($urandom));
                6: prog[i] = enc_i(6'h2B, 5'd0, b, 16'(($urandom % (2 * DM)) * 4));
                7: prog[i] = enc_i(6'h23, 5'd0, d, 16'(($urandom % (2 * DM)) * 4));
                8: prog[i] = enc_i(6'h04, a, b, 16'h0001);
                default: prog[i] = enc_r(5'd0, b, d, 6'h22);
            endcase
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] ins;
        string tag, pc_tag;
        void'($urandom(32'd7741));
        build_prog();
        for (int i = 0; i < 32; i++) mreg[i] = '0;
        for (int i = 0; i < DM; i++) mmem[i] = '0;
        mpc = '0;

        // load program under reset (R10), checking reset state (R1)
        @(negedge clk);
        for (int i = 0; i < IM; i++) begin
            ld_en   = 1'b1;
            ld_addr = IAW'(i);
            ld_data = prog[i];
            @(negedge clk);
            if (i % 32 == 0) begin
                chk("R1", "pc in reset", dbg_pc, 32'd0);
                chk("R1", "wen in reset", {31'd0, dbg_wen}, 32'd0);
            end
        end
        ld_en = 1'b0;
        @(negedge clk);
        chk("R1", "pc in reset", dbg_pc, 32'd0);
        chk("R1", "wen in reset", {31'd0, dbg_wen}, 32'd0);
        rst = 1'b0;

        pc_tag = "R1";
        for (int c = 0; c < RUN_CYCLES; c++) begin
            #1;
            model_eval(ins);
            tag = (c == 0) ? "R10" : req_of(ins);
            chk(pc_tag, "pc", dbg_pc, mpc);
            chk(tag, "wen", {31'd0, dbg_wen}, {31'd0, e_wen});
            if (e_wen) begin
                chk(tag, "waddr", {27'd0, dbg_waddr}, {27'd0, e_wa});
                chk(tag, "wdata", dbg_wdata, e_wd);
            end
            if (ins[31:26] == 6'h04 || (ins[31:26] == 6'h00 && ins[5:0] == 6'h08))
                pc_tag = req_of(ins);
            else
                pc_tag = (ins[31:26] == 6'h00 || ins[31:26] == 6'h0F || ins[31:26] == 6'h23
                          || ins[31:26] == 6'h2B) ? "R2" : "R11";
            model_commit();
            @(negedge clk);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule